// File: doc/BRIEF.md
# Host interrupt status controller

This block gathers single-cycle event pulses from internal sources into a pending-status vector and raises one interrupt line toward a host. The host reaches the block through a small word-addressed register port. It can block individual sources with a mask, and it can change that mask either by loading the whole mask or with write-1-to-set and write-1-to-clear accesses that leave the other bits alone. It reads pending status either without side effects or with a read that empties the whole vector. It can also retire chosen bits with a write-1-to-acknowledge register.

Only eighteen bit positions are defined, and only some of them carry a source. Bit 0 and bit 3 are the two receive buffers. Bit 1 is transmit data, bit 2 is transmit transfer and bit 4 is receive transfer. Bits 5 and 6 are the two event mailboxes. Bit 7 is wake. Bits 8 and 9 are the two trace sources. Bit 10 is command complete and bit 14 is init complete. Bits 16 and 17 are sense enable and sense disable. Positions 11, 12, 13 and 15 have no flop behind them. A configuration register turns the interrupt line on and selects its polarity.

Read data is combinational and is valid in the cycle in which `rd_en_i` is high. The side effects of that cycle, such as the clear-on-read, take effect at the clock edge that ends it.

Top module: `hint_ctrl`

## Requirements
- R1: After reset, every mask bit is 1, every status bit is 0, the configuration register is 0 and `host_irq_o` is 0.
- R2: A write to address 1 loads the mask from `wr_data_i[17:0]`. A read of address 1 returns the mask in bits 17:0 and 0 above them.
- R3: A write to address 2 sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to address 3 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R5: A read of address 4 returns the status vector in bits 17:0 and changes no state.
- R6: A read of address 5 returns the status vector, and all status bits are 0 after that cycle unless an event arrives in the same cycle.
- R7: A write to address 6 clears each status bit whose data bit is 1. The cleared bit is seen through both address 4 and address 5. Data bits of 0 have no effect.
- R8: An event pulse on `evt_i[i]` sets status bit i on the next edge, and the bit stays set until it is cleared. Positions 11, 12, 13 and 15 always read 0.
- R9: An event on a bit in the same cycle as a clear-on-read or acknowledge of that bit leaves the bit set.
- R10: With configuration bit 0 (enable) at 1 and bit 1 (active-low) at 0, `host_irq_o` is 1 exactly when some status bit is 1 while its mask bit is 0.
- R11: Configuration bit 1 inverts `host_irq_o`. With bit 0 at 0, the line stays at its inactive level, which equals bit 1. A read of address 0 returns the two bits in bits 1:0.
- R12: Reads of addresses 2, 3, 6 and 7 return 0. A write to address 4, 5 or 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 18 | Event pulses, one per source position |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe (enables read side effects) |
| rd_data_o | output | 32 | Read data, valid while rd_en_i is high |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
The hardest case to reach is an event that lands in the same cycle as a clear of its own bit. Either the clear is an acknowledge write with that bit set, or it is a clear-on-read. Only then does the event-over-clear priority decide the result. Directed cycles pair an event with an acknowledge of the same bit, and with a clear-on-read, and then read status without side effects. A long random phase fires sparse events on all eighteen positions, including the empty ones, while reads and writes hit every address. This makes such collisions occur many times over, each against a bench model.

// File: rtl/hint_pkg.sv
`timescale 1ns/1ps
package hint_pkg;
    localparam int NUM_SRC = 18;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    // positions that carry a source: 0..10, 14, 16, 17
    localparam logic [NUM_SRC-1:0] SRC_PRESENT = 18'h347FF;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG  = 3'd0,
        REG_MASK = 3'd1,
        REG_MSET = 3'd2,
        REG_MCLR = 3'd3,
        REG_PEEK = 3'd4,
        REG_TAKE = 3'd5,
        REG_ACK  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic act_low;
        logic enable;
    } irq_cfg_t;

    typedef struct packed {
        logic wr_cfg;
        logic wr_mask;
        logic wr_mset;
        logic wr_mclr;
        logic wr_ack;
        logic rd_peek;
        logic rd_take;
    } bus_op_t;

    function automatic bus_op_t decode_op(input logic [ADDR_W-1:0] a,
                                          input logic wr, input logic rd);
        bus_op_t op;
        op = '0;
        op.wr_cfg  = wr && (a == REG_CFG);
        op.wr_mask = wr && (a == REG_MASK);
        op.wr_mset = wr && (a == REG_MSET);
        op.wr_mclr = wr && (a == REG_MCLR);
        op.wr_ack  = wr && (a == REG_ACK);
        op.rd_peek = rd && (a == REG_PEEK);
        op.rd_take = rd && (a == REG_TAKE);
        return op;
    endfunction
endpackage

// File: rtl/hint_mask_reg.sv
`timescale 1ns/1ps
module hint_mask_reg #(
    parameter int N = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_load_i,
    input  logic         wr_set_i,
    input  logic         wr_clr_i,
    input  logic [N-1:0] data_i,
    output logic [N-1:0] mask_o
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)            mask_q <= '1;
        else if (wr_load_i) mask_q <= data_i;
        else if (wr_set_i)  mask_q <= mask_q | data_i;
        else if (wr_clr_i)  mask_q <= mask_q & ~data_i;
    end

    assign mask_o = mask_q;

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_load_i |=> (mask_q == $past(data_i)));
    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_set_i |=> (((mask_q & $past(data_i)) == $past(data_i)) &&
                      ((mask_q & ~$past(data_i)) == ($past(mask_q) & ~$past(data_i)))));
    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr_i |=> (((mask_q & $past(data_i)) == '0) &&
                      ((mask_q & ~$past(data_i)) == ($past(mask_q) & ~$past(data_i)))));
endmodule

// File: rtl/hint_status_reg.sv
`timescale 1ns/1ps
module hint_status_reg #(
    parameter int           N       = 18,
    parameter logic [N-1:0] PRESENT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] ack_i,
    input  logic         take_i,
    output logic [N-1:0] stat_o
);
    logic [N-1:0] stat_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (PRESENT[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)                     stat_q[i] <= 1'b0;
                else if (evt_i[i])           stat_q[i] <= 1'b1;
                else if (take_i || ack_i[i]) stat_q[i] <= 1'b0;
            end
        end else begin : g_empty
            logic [1:0] unused_bits;
            assign unused_bits = {evt_i[i], ack_i[i]};
            assign stat_q[i]   = 1'b0;
        end
    end

    assign stat_o = stat_q;

    // R9
    evt_keep_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(evt_i & PRESENT)) == $past(evt_i & PRESENT)));
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|ack_i && !(|evt_i)) |=> ((stat_q & $past(ack_i)) == '0));
    // R8
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~PRESENT) == '0);
endmodule

// File: rtl/hint_irq_out.sv
`timescale 1ns/1ps
module hint_irq_out
    import hint_pkg::*;
#(
    parameter int N = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] mask_i,
    input  irq_cfg_t     cfg_i,
    output logic         irq_o
);
    logic pending;

    assign pending = |(stat_i & ~mask_i);
    assign irq_o   = (cfg_i.enable & pending) ^ cfg_i.act_low;

    // R11
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.enable |-> (irq_o == cfg_i.act_low));
endmodule

// File: rtl/hint_ctrl.sv
`timescale 1ns/1ps
module hint_ctrl
    import hint_pkg::*;
#(
    parameter int           N       = NUM_SRC,
    parameter int           DW      = DATA_W,
    parameter int           AW      = ADDR_W,
    parameter logic [N-1:0] PRESENT = SRC_PRESENT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  evt_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    output logic [DW-1:0] rd_data_o,
    output logic          host_irq_o
);
    localparam int PAD = DW - N;

    bus_op_t      op;
    irq_cfg_t     cfg_q;
    logic [N-1:0] mask;
    logic [N-1:0] stat;
    logic [N-1:0] wdata;
    logic [N-1:0] ack_bits;
    logic         unused_wr_hi;

    assign op           = decode_op(addr_i, wr_en_i, rd_en_i);
    assign wdata        = wr_data_i[N-1:0];
    assign unused_wr_hi = ^wr_data_i[DW-1:N];
    assign ack_bits     = op.wr_ack ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst)            cfg_q <= '0;
        else if (op.wr_cfg) cfg_q <= irq_cfg_t'(wr_data_i[1:0]);
    end

    hint_mask_reg #(.N(N)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .wr_load_i (op.wr_mask),
        .wr_set_i  (op.wr_mset),
        .wr_clr_i  (op.wr_mclr),
        .data_i    (wdata),
        .mask_o    (mask)
    );

    hint_status_reg #(.N(N), .PRESENT(PRESENT)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .ack_i  (ack_bits),
        .take_i (op.rd_take),
        .stat_o (stat)
    );

    hint_irq_out #(.N(N)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .stat_i (stat),
        .mask_i (mask),
        .cfg_i  (cfg_q),
        .irq_o  (host_irq_o)
    );

    always_comb begin
        case (addr_i)
            REG_CFG:  rd_data_o = {{(DW-2){1'b0}}, cfg_q};
            REG_MASK: rd_data_o = {{PAD{1'b0}}, mask};
            REG_PEEK,
            REG_TAKE: rd_data_o = {{PAD{1'b0}}, stat};
            default:  rd_data_o = '0;
        endcase
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> ((mask == '1) && (stat == '0) && (cfg_q == '0) && !host_irq_o));
    // R6
    take_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (op.rd_take && !(|evt_i)) |=> (stat == '0));
    // R5
    peek_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (op.rd_peek && !(|evt_i) && !wr_en_i) |=> $stable(stat));
    // R10
    irq_active_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.enable && |(stat & ~mask)) |-> (host_irq_o == !cfg_q.act_low));
endmodule

// File: tb/hint_ctrl_tb.sv
`timescale 1ns/1ps
module hint_ctrl_tb;
    localparam int N  = 18;
    localparam int DW = 32;
    localparam logic [N-1:0] LIVE = 18'h347FF;
    localparam logic [2:0] A_CFG = 3'd0, A_MASK = 3'd1, A_MSET = 3'd2, A_MCLR = 3'd3,
                           A_PEEK = 3'd4, A_TAKE = 3'd5, A_ACK = 3'd6, A_NONE = 3'd7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  evt = '0;
    logic [2:0]    addr = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          host_irq;

    always #2 clk = ~clk;

    hint_ctrl u_dut (
        .clk(clk), .rst(rst), .evt_i(evt), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .host_irq_o(host_irq)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [N-1:0] m_mask = '1, m_stat = '0;
    logic [1:0]   m_cfg = '0;

    function automatic logic [DW-1:0] exp_read(input logic [2:0] a);
        case (a)
            A_CFG:          return {30'b0, m_cfg};
            A_MASK:         return {14'b0, m_mask};
            A_PEEK, A_TAKE: return {14'b0, m_stat};
            default:        return '0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_cfg[0] & (|(m_stat & ~m_mask))) ^ m_cfg[1];
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            A_CFG:  return "R11 cfg read";
            A_MASK: return "R2 R3 R4 mask read";
            A_PEEK: return "R5 R7 R8 peek read";
            A_TAKE: return "R6 R9 take read";
            default: return "R12 empty read";
        endcase
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [N-1:0] e, input logic [2:0] a, input logic w,
                         input logic [DW-1:0] d, input logic r, input string tag);
        logic [N-1:0] clr;
        evt = e; addr = a; wr_en = w; wr_data = d; rd_en = r;
        #1;
        if (r) check(tag, rd_data, exp_read(a));
        check("R10 R11 host_irq", {31'b0, host_irq}, {31'b0, exp_irq()});
        clr = '0;
        if (r && a == A_TAKE) clr = '1;
        if (w && a == A_ACK)  clr = clr | d[N-1:0];
        m_stat = (m_stat & ~clr) | (e & LIVE);
        if (w) begin
            case (a)
                A_CFG:  m_cfg  = d[1:0];
                A_MASK: m_mask = d[N-1:0];
                A_MSET: m_mask = m_mask | d[N-1:0];
                A_MCLR: m_mask = m_mask & ~d[N-1:0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        cycle('0, a, 1'b0, '0, 1'b1, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        cycle('0, a, 1'b1, d, 1'b0, "R12 write");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CFG,  "R1 cfg");
        rd(A_MASK, "R1 mask");
        rd(A_PEEK, "R1 status");
        rd(A_NONE, "R12 unused addr");

        // R8 latching, empty positions stay 0
        cycle(18'h3FFFF, A_PEEK, 1'b0, '0, 1'b1, "R8 same-cycle read");
        rd(A_PEEK, "R8 latched");
        rd(A_PEEK, "R5 repeat peek");
        cycle('0, A_PEEK, 1'b1, 32'h3FFFF, 1'b1, "R12 write to peek");
        rd(A_PEEK, "R12 peek after write");

        // R7 acknowledge
        wr(A_ACK, 32'h1);
        rd(A_PEEK, "R7 ack bit0 peek");
        rd(A_ACK,  "R12 ack read");
        wr(A_ACK, 32'h0);
        rd(A_PEEK, "R7 ack zero");

        // R9 event vs acknowledge
        cycle(18'h00002, A_ACK, 1'b1, 32'h2, 1'b0, "R9 evt+ack");
        rd(A_PEEK, "R9 evt beats ack");

        // R6 clear-on-read
        rd(A_TAKE, "R6 take read");
        rd(A_PEEK, "R6 after take");
        wr(A_ACK, 32'h3FFFF);
        cycle(18'h00400, A_TAKE, 1'b0, '0, 1'b1, "R9 evt+take");
        rd(A_PEEK, "R9 evt beats take");
        rd(A_TAKE, "R6 take again");

        // R2 R3 R4 mask
        wr(A_MASK, 32'hFFFC_F0F0);
        rd(A_MASK, "R2 mask load");
        wr(A_MSET, 32'h3);
        rd(A_MASK, "R3 mask set");
        wr(A_MCLR, 32'hF0);
        rd(A_MASK, "R4 mask clear");
        rd(A_MSET, "R12 mset read");

        // R10 R11 output
        wr(A_CFG, 32'h1);
        rd(A_CFG, "R11 cfg enable");
        cycle(18'h00001, A_PEEK, 1'b0, '0, 1'b1, "R10 masked evt");
        rd(A_PEEK, "R10 masked pending");
        cycle(18'h00004, A_PEEK, 1'b0, '0, 1'b1, "R10 open evt");
        rd(A_PEEK, "R10 irq high");
        wr(A_CFG, 32'h3);
        rd(A_CFG, "R11 active low");
        wr(A_MSET, 32'h4);
        rd(A_MASK, "R10 masked again");
        wr(A_CFG, 32'h2);
        wr(A_MCLR, 32'h3FFFF);
        rd(A_PEEK, "R11 disabled idle");
        wr(A_CFG, 32'h1);
        rd(A_TAKE, "R6 final take");
        rd(A_PEEK, "R10 irq drops");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] rv, ev, dv;
            logic [2:0]  a;
            rv = $urandom;
            ev = $urandom;
            dv = $urandom;
            a  = rv[2:0];
            cycle((rv[7:4] == 4'd0) ? ev[N-1:0] : '0, a,
                  rv[9:8] == 2'd0, dv, rv[10], tag_of(a));
        end
        rd(A_PEEK, "R8 final status");
        rd(A_MASK, "R2 final mask");

        done = 1'b1;
        finish_run();
    end
endmodule